// File: doc/BRIEF.md
# I2C Slave Receiver with Event Status Codes

This block is the receive half of an I2C target. It follows the SCL and SDA lines through a two-stage synchroniser and finds START and STOP conditions. It compares the first byte after a START with its programmed 7-bit address, or with the broadcast address 0x00 when broadcast reception is enabled. It then shifts the following bytes in, most significant bit first.

Each defined bus event is reported to a CPU. The block raises an event flag, shows a byte-wide status code and holds SCL low until the CPU has dealt with the event. An acknowledge-enable flag decides whether the block pulls SDA low in the acknowledge slot. The CPU reads and writes five byte registers on a simple write-strobe bus, with a combinational read path.

Register map (byte offsets):
- 0 is flag set. Writing a 1 to bit 0 sets the acknowledge-enable flag. A read returns bit 0 = acknowledge enable and bit 1 = event flag.
- 1 is status, which is read-only.
- 2 is data.
- 3 is the self address. Bits 7:1 hold the 7-bit address and bit 0 enables broadcast reception.
- 4 is flag clear. Writing a 1 to bit 0 clears acknowledge enable, and a 1 in bit 1 clears the event flag. It reads as 0.

Top module: `i2c_status_slave`

## Requirements
- R1: The status register at offset 1 always reads with bits 2:0 equal to 0. Writes to offset 1 change nothing.
- R2: While the event flag is clear, status reads 0xF8. After reset, status is 0xF8, both flags are 0, and data and self address are 0x00.
- R3: An address byte with bits 7:1 equal to self-address bits 7:1 (non-zero) and bit 0 = 0 is accepted when acknowledge enable is 1. The block pulls SDA low in the acknowledge slot, sets the event flag and shows 0x60. Any other address, a byte with bit 0 = 1, or acknowledge enable at 0 gives no acknowledge and no event.
- R4: With self-address bit 0 = 1 and acknowledge enable set, address byte 0x00 is acknowledged with status 0x70. With bit 0 = 0, byte 0x00 is ignored.
- R5: A data byte received while addressed is stored at offset 2, first bit received in bit 7. With acknowledge enable set it is acknowledged, with status 0x80, or 0x90 after a broadcast address.
- R6: With acknowledge enable clear, a data byte received while addressed is not acknowledged and shows 0x88, or 0x98 after a broadcast address. Later bytes raise no event and leave data unchanged until the next START.
- R7: While the event flag is set, SCL is held low. Writing 1 to bit 1 at offset 4 clears the flag and releases SCL.
- R8: Writing 1 to bit 0 at offset 0 sets acknowledge enable. Writing 1 to bit 0 at offset 4 clears it. Zero bits written to either register have no effect, and offset 0 cannot set the event flag.
- R9: Writes to offset 2 take effect only while the event flag is set. The bus does not change the data register while the flag stays set.
- R10: A STOP, or a repeated START, while addressed sets the event flag with status 0xA0.
- R11: When a bus event and a CPU write that clears the event flag fall in the same clock cycle, the event wins and the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_hold | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull | output | 1 | 1 pulls SDA low (acknowledge) |
| reg_addr | input | 3 | Register offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |

## Verification
Two things can land in the same clock cycle: the event flag being set by a STOP while the block is addressed, and a CPU write that clears that flag. The bench raises SDA while SCL is high, counts the two synchroniser stages, and presents the clear write on exactly the cycle in which the STOP is registered. It then expects the flag to read 1 and the status to read 0xA0. The main sweeps go through all 128 address values against one programmed address, and through a spread of data byte values.

// File: rtl/i2c_status_slave.sv
module i2c_status_slave (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_hold,
  output logic       sda_pull,
  input  logic [2:0] reg_addr,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);
  localparam logic [2:0] A_SET = 3'd0, A_STAT = 3'd1, A_DATA = 3'd2, A_SELF = 3'd3, A_CLR = 3'd4;
  localparam logic [7:0] C_NONE = 8'hF8, C_ADR = 8'h60, C_GC = 8'h70, C_DACK = 8'h80,
                         C_DNAK = 8'h88, C_GACK = 8'h90, C_GNAK = 8'h98, C_END = 8'hA0;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  st_t        st;
  logic [3:0] bcnt;
  logic [7:0] shreg, code, dat, self_a;
  logic       aa, si, gc_mode, in_ack, ack_drv, nack_end;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  wire wr_set  = reg_we && reg_addr == A_SET;
  wire wr_clr  = reg_we && reg_addr == A_CLR;
  wire wr_dat  = reg_we && reg_addr == A_DATA;
  wire wr_self = reg_we && reg_addr == A_SELF;

  wire byte_end = scl_fall && bcnt == 4'd8 && !in_ack && st != S_IDLE;
  wire gc_hit   = shreg == 8'h00 && self_a[0];
  wire own_hit  = shreg[7:1] == self_a[7:1] && !shreg[0] && shreg[7:1] != 7'd0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bcnt <= '0; shreg <= '0; code <= C_NONE; dat <= '0; self_a <= '0;
      aa <= 1'b0; si <= 1'b0; gc_mode <= 1'b0; in_ack <= 1'b0; ack_drv <= 1'b0; nack_end <= 1'b0;
    end else begin
      if (wr_set && reg_wdata[0]) aa <= 1'b1;
      if (wr_clr && reg_wdata[0]) aa <= 1'b0;
      if (wr_clr && reg_wdata[1]) si <= 1'b0;
      if (wr_dat && si) dat <= reg_wdata;
      if (wr_self) self_a <= reg_wdata;

      if (scl_rise && st != S_IDLE && !in_ack && bcnt < 4'd8) begin
        shreg <= {shreg[6:0], sda_s};
        bcnt  <= bcnt + 4'd1;
      end

      if (in_ack && scl_fall) begin
        in_ack  <= 1'b0;
        ack_drv <= 1'b0;
        bcnt    <= '0;
        if (nack_end) st <= S_IDLE;
      end

      if (byte_end) begin
        if (st == S_ADDR) begin
          if (aa && (own_hit || gc_hit)) begin
            st <= S_DATA; gc_mode <= gc_hit; si <= 1'b1; dat <= shreg;
            code <= gc_hit ? C_GC : C_ADR;
            in_ack <= 1'b1; ack_drv <= 1'b1; nack_end <= 1'b0;
          end else
            st <= S_IDLE;
        end else begin
          si <= 1'b1; dat <= shreg; in_ack <= 1'b1; ack_drv <= aa; nack_end <= !aa;
          code <= gc_mode ? (aa ? C_GACK : C_GNAK) : (aa ? C_DACK : C_DNAK);
        end
      end

      if (start_det || stop_det) begin
        if (st == S_DATA) begin
          si <= 1'b1; code <= C_END;
        end
        st <= start_det ? S_ADDR : S_IDLE;
        bcnt <= '0; in_ack <= 1'b0; ack_drv <= 1'b0;
      end
    end

  assign scl_hold = si;
  assign sda_pull = ack_drv;

  always_comb
    case (reg_addr)
      A_SET:   reg_rdata = {6'b0, si, aa};
      A_STAT:  reg_rdata = si ? code : C_NONE;
      A_DATA:  reg_rdata = dat;
      A_SELF:  reg_rdata = self_a;
      default: reg_rdata = 8'h00;
    endcase

  p_stat_low_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == A_STAT |-> reg_rdata[2:0] == 3'b000);

  p_ack_needs_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(aa));

  p_event_has_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(si) |-> code != C_NONE);

  p_data_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (si && $past(si) && !$past(wr_dat)) |-> dat == $past(dat));

  p_nack_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_ack && scl_fall && nack_end && !start_det && !stop_det) |-> st == S_IDLE);

  p_stop_unaddr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> st == S_IDLE);
endmodule

// File: tb/sim_i2c_status_slave.sv
module sim_i2c_status_slave;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_hold, sda_pull;
  logic [2:0] reg_addr = 3'd0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  int checks = 0, errors = 0;

  wire scl_line = m_scl & ~scl_hold;
  wire sda_line = m_sda & ~sda_pull;

  always #(CLK_NS/2) clk = ~clk;

  i2c_status_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .scl_hold(scl_hold), .sda_pull(sda_pull), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_wdata = v; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic scl_hi;
    m_scl = 1'b1;
    while (scl_line !== 1'b1) @(negedge clk);
    idle(4);
  endtask

  task automatic scl_lo;
    m_scl = 1'b0;
    idle(4);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; idle(2);
    scl_hi;
    m_sda = 1'b0; idle(4);
    scl_lo;
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; idle(2);
    scl_hi;
    m_sda = 1'b1; idle(6);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; idle(2);
      scl_hi;
      scl_lo;
    end
    m_sda = 1'b1; idle(4);
  endtask

  task automatic ack_clock(output logic ack);
    scl_hi;
    ack = ~sda_line;
    scl_lo;
  endtask

  task automatic expect_event(input string req, input logic [7:0] code);
    logic [7:0] v;
    rd(3'd0, v); chk({req, " event flag"}, v[1], 1);
    rd(3'd1, v); chk({req, " status"}, v, code);
    wr(3'd4, 8'h02);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic ack;
    idle(3); rst_n = 1'b1; idle(3);

    rd(3'd1, v); chk("R2 reset status", v, 8'hF8);
    rd(3'd0, v); chk("R2 reset flags", v, 0);
    rd(3'd2, v); chk("R2 reset data", v, 0);
    rd(3'd3, v); chk("R2 reset self", v, 0);
    wr(3'd1, 8'hFF);
    rd(3'd1, v); chk("R1 status read-only", v, 8'hF8);

    wr(3'd3, 8'h54);
    bus_start; send_byte(8'h54);
    rd(3'd0, v); chk("R3 no event with flag clear", v[1], 0);
    ack_clock(ack); chk("R3 no ack with flag clear", ack, 0);
    bus_stop;

    wr(3'd0, 8'h02);
    rd(3'd0, v); chk("R8 set reg cannot raise event", v, 0);
    wr(3'd0, 8'h01);
    rd(3'd0, v); chk("R8 ack enable set", v, 1);
    wr(3'd4, 8'h00);
    rd(3'd0, v); chk("R8 zero clear no effect", v, 1);
    wr(3'd2, 8'h3C);
    rd(3'd2, v); chk("R9 data write ignored when idle", v, 0);

    for (int a = 0; a < 128; a++) begin
      bus_start; send_byte(8'(a << 1));
      rd(3'd0, v);
      chk("R3 address sweep event", v[1], (a == 8'h2A) ? 1 : 0);
      if (a == 8'h2A) begin
        rd(3'd1, v); chk("R3 status own address", v, 8'h60);
        rd(3'd1, v); chk("R1 low bits zero", v[2:0], 0);
        m_scl = 1'b1; idle(6);
        chk("R7 scl held low", scl_line, 0);
        wr(3'd4, 8'h02); idle(4);
        chk("R7 scl released", scl_line, 1);
        ack = ~sda_line; scl_lo;
      end else
        ack_clock(ack);
      chk("R3 address sweep ack", ack, (a == 8'h2A) ? 1 : 0);
      bus_stop;
      if (a == 8'h2A) expect_event("R10 stop", 8'hA0);
      else begin rd(3'd0, v); chk("R10 stop unaddressed no event", v[1], 0); end
    end

    bus_start; send_byte(8'h55);
    rd(3'd0, v); chk("R3 read bit ignored", v[1], 0);
    ack_clock(ack); chk("R3 read bit no ack", ack, 0);
    bus_stop;

    bus_start; send_byte(8'h54);
    expect_event("R3 address", 8'h60);
    ack_clock(ack);
    for (int d = 0; d < 256; d += 3) begin
      send_byte(8'(d));
      rd(3'd1, v); chk("R5 data status", v, 8'h80);
      rd(3'd2, v); chk("R5 data msb first", v, d);
      if (d == 99) begin
        wr(3'd2, 8'hC3);
        rd(3'd2, v); chk("R9 data write while event", v, 8'hC3);
      end
      wr(3'd4, 8'h02);
      ack_clock(ack); chk("R5 data ack", ack, 1);
    end
    bus_start;
    expect_event("R10 repeated start", 8'hA0);
    send_byte(8'h54);
    expect_event("R3 readdress", 8'h60);
    ack_clock(ack);

    wr(3'd4, 8'h01);
    send_byte(8'h99);
    rd(3'd1, v); chk("R6 nack status", v, 8'h88);
    rd(3'd2, v); chk("R6 nack data", v, 8'h99);
    wr(3'd4, 8'h02);
    ack_clock(ack); chk("R6 nack on line", ack, 0);
    send_byte(8'h12);
    rd(3'd0, v); chk("R6 later byte no event", v[1], 0);
    rd(3'd1, v); chk("R2 idle status", v, 8'hF8);
    rd(3'd2, v); chk("R6 data unchanged", v, 8'h99);
    ack_clock(ack); chk("R6 later byte no ack", ack, 0);
    bus_stop;
    rd(3'd0, v); chk("R6 stop after nack no event", v[1], 0);

    wr(3'd3, 8'h55); wr(3'd0, 8'h01);
    bus_start; send_byte(8'h00);
    expect_event("R4 broadcast", 8'h70);
    ack_clock(ack); chk("R4 broadcast ack", ack, 1);
    send_byte(8'h6E);
    rd(3'd2, v); chk("R5 broadcast data", v, 8'h6E);
    expect_event("R5 broadcast data", 8'h90);
    ack_clock(ack); chk("R5 broadcast data ack", ack, 1);
    wr(3'd4, 8'h01);
    send_byte(8'h11);
    expect_event("R6 broadcast nack", 8'h98);
    ack_clock(ack); chk("R6 broadcast nack line", ack, 0);
    bus_stop;

    wr(3'd3, 8'h54); wr(3'd0, 8'h01);
    bus_start; send_byte(8'h00);
    rd(3'd0, v); chk("R4 broadcast disabled", v[1], 0);
    ack_clock(ack); chk("R4 broadcast disabled no ack", ack, 0);
    bus_stop;

    bus_start; send_byte(8'h54);
    expect_event("R11 setup", 8'h60);
    ack_clock(ack);
    m_sda = 1'b0; idle(2);
    scl_hi;
    @(negedge clk); m_sda = 1'b1;
    @(negedge clk);
    @(negedge clk); reg_addr = 3'd4; reg_wdata = 8'h02; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
    rd(3'd0, v); chk("R11 event beats clear", v[1], 1);
    rd(3'd1, v); chk("R11 status after collision", v, 8'hA0);
    wr(3'd4, 8'h02);
    rd(3'd1, v); chk("R2 status after clear", v, 8'hF8);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule